// File: doc/BRIEF.md
# USB Device Interrupt Status Controller

This block keeps the interrupt status word of a USB device controller, together with a small interrupt enable register, and drives a single interrupt request line. One-cycle event pulses from the surrounding logic set sticky flags. Those pulses come from the bus-state monitor, the attach detector, the wake-up logic, the six endpoint responders and the setup-token detector. The flags stay set until software clears them.

Software clears flags by writing ones into the status word. The clears are coupled, so one write can retire a whole group of related flags.

- The summary USB flag is set whenever any endpoint flag or the setup flag is set.
- Clearing the summary flag also retires every endpoint flag.
- Clearing any endpoint flag, or the setup flag, also retires the summary flag.

Register access is a plain 32-bit write strobe with an address, plus a read path that reflects the selected register in the same cycle.

Status bit positions are fixed, because interrupt service software decodes them:

| Bit | Flag |
|-----|------|
| 0 | bus event |
| 1 | USB summary |
| 2 | attach |
| 3 | wake-up |
| 16+n | endpoint n (n = 0..5) |
| 31 | setup |

Enable bit i (i = 0..3) gates the group named by status bit i. The endpoint flags and the setup flag fall in the USB group and are gated by enable bit 1.

Top module: `usb_irq_ctrl`

## Requirements
- R1: After reset the status word, the enable register and `irqOut` are all zero.
- R2: Each event pulse sets its flag in the status word, visible in the cycle after the pulse:
  - `busEvtPulse` sets bit 0.
  - `attachEvtPulse` sets bit 2.
  - `wakeEvtPulse` sets bit 3.
  - `epEvtPulse[n]` sets bit 16+n and also bit 1.
  - `setupEvtPulse` sets bit 31 and also bit 1.
- R3: A status write (address 0) clears bits 0, 2 and 3 only where the written data has a 1 in that same position. Writing 0 to any bit changes nothing.
- R4: Status bit 1 is cleared by writing 1 to bit 1, to bit 31, or to any of bits 16..21.
- R5: Endpoint bit 16+n is cleared by writing 1 to bit 16+n or to bit 1. Other endpoint bits are untouched.
- R6: Status bit 31 is cleared only by writing 1 to bit 31. A write with bit 1 set leaves it in place.
- R7: When an event pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R8: The enable register (address 1) is written from data bits 3..0, reads back in bits 3..0 with all upper bits zero, and is unaffected by status writes.
- R9: `irqOut` is high exactly when at least one of these holds:
  - enabled bit 0 is set and bit 0 is set;
  - enabled bit 2 is set and bit 2 is set;
  - enabled bit 3 is set and bit 3 is set;
  - enabled bit 1 is set and any of bit 1, bits 16..21 or bit 31 is set.
- R10: Flags are set even while their interrupt is disabled, can be read by polling, and raise `irqOut` as soon as their enable is later written to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | 2 | Register select: 0 status word, 1 enable register, others read zero |
| regWrData | input | 32 | Write data; for the status word a 1 requests a clear |
| regRdData | output | 32 | Contents of the register selected by `regAddr` |
| busEvtPulse | input | 1 | Bus suspend/resume event pulse |
| attachEvtPulse | input | 1 | Attach detection event pulse |
| wakeEvtPulse | input | 1 | Wake-up event pulse |
| epEvtPulse | input | 6 | Per-endpoint transaction event pulses |
| setupEvtPulse | input | 1 | Setup token event pulse |
| irqOut | output | 1 | Interrupt request line |

## Verification
A wrong flag shows on `regRdData` whenever address 0 is selected. It appears in the cycle right after the edge that set or cleared it.

A coupling fault appears only on the second bit of a pair. For example, a summary flag that survives an endpoint clear, or a setup flag lost on a summary clear. Each pair is therefore driven separately and read back after one write.

A wrong enable or gating term shows on `irqOut` in the same cycle as the flag or enable change, with no extra register delay.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  parameter int unsigned DATA_W = 32;
  parameter int unsigned NUM_EP = 6;
  parameter int unsigned EN_W   = 4;
  parameter int unsigned ADDR_W = 2;

  // Status bit positions are decoded by software and must stay put.
  localparam int unsigned BIT_BUS   = 0;
  localparam int unsigned BIT_USB   = 1;
  localparam int unsigned BIT_ATT   = 2;
  localparam int unsigned BIT_WAKE  = 3;
  localparam int unsigned BIT_EP0   = 16;
  localparam int unsigned BIT_SETUP = DATA_W - 1;

  localparam logic [ADDR_W-1:0] ADDR_STATUS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = ADDR_W'(1);

  typedef struct packed {
    logic [DATA_W-1:0] clrMask;
    logic              enWr;
    logic [EN_W-1:0]   enData;
    logic              rdStatus;
    logic              rdEnable;
  } strobes_t;
endpackage

// File: rtl/usb_irq_regctl.sv
module usb_irq_regctl
  import usb_irq_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output strobes_t          strb
);
  logic wrStatus;
  logic anyEpClr;
  logic unusedData;

  assign unusedData = ^regWrData;
  assign wrStatus   = regWrEn && (regAddr == ADDR_STATUS);
  assign anyEpClr   = |regWrData[BIT_EP0 +: NUM_EP];

  always_comb begin
    strb = '0;
    if (wrStatus) begin
      strb.clrMask[BIT_BUS]   = regWrData[BIT_BUS];
      strb.clrMask[BIT_ATT]   = regWrData[BIT_ATT];
      strb.clrMask[BIT_WAKE]  = regWrData[BIT_WAKE];
      strb.clrMask[BIT_SETUP] = regWrData[BIT_SETUP];
      strb.clrMask[BIT_USB]   = regWrData[BIT_USB] | regWrData[BIT_SETUP] | anyEpClr;
      for (int n = 0; n < NUM_EP; n++) begin
        strb.clrMask[BIT_EP0 + n] = regWrData[BIT_EP0 + n] | regWrData[BIT_USB];
      end
    end
    strb.enWr     = regWrEn && (regAddr == ADDR_ENABLE);
    strb.enData   = regWrData[EN_W-1:0];
    strb.rdStatus = (regAddr == ADDR_STATUS);
    strb.rdEnable = (regAddr == ADDR_ENABLE);
  end
endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status
  import usb_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  strobes_t          strb,
  input  logic              busEvtPulse,
  input  logic              attachEvtPulse,
  input  logic              wakeEvtPulse,
  input  logic [NUM_EP-1:0] epEvtPulse,
  input  logic              setupEvtPulse,
  output logic [DATA_W-1:0] statusWord,
  output logic [EN_W-1:0]   enableWord,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  logic [DATA_W-1:0] setMask;
  logic [DATA_W-1:0] statusQ;
  logic [EN_W-1:0]   enQ;
  logic              usbGroup;

  always_comb begin
    setMask            = '0;
    setMask[BIT_BUS]   = busEvtPulse;
    setMask[BIT_ATT]   = attachEvtPulse;
    setMask[BIT_WAKE]  = wakeEvtPulse;
    setMask[BIT_SETUP] = setupEvtPulse;
    setMask[BIT_USB]   = (|epEvtPulse) | setupEvtPulse;
    for (int n = 0; n < NUM_EP; n++) begin
      setMask[BIT_EP0 + n] = epEvtPulse[n];
    end
  end

  // Set has priority over a clear arriving in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statusQ <= '0;
    end else begin
      statusQ <= (statusQ & ~strb.clrMask) | setMask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enQ <= '0;
    end else if (strb.enWr) begin
      enQ <= strb.enData;
    end
  end

  assign usbGroup = statusQ[BIT_USB] | (|statusQ[BIT_EP0 +: NUM_EP]) | statusQ[BIT_SETUP];

  assign irqOut = (statusQ[BIT_BUS]  & enQ[BIT_BUS])
                | (statusQ[BIT_ATT]  & enQ[BIT_ATT])
                | (statusQ[BIT_WAKE] & enQ[BIT_WAKE])
                | (usbGroup          & enQ[BIT_USB]);

  always_comb begin
    if (strb.rdStatus)      regRdData = statusQ;
    else if (strb.rdEnable) regRdData = {{(DATA_W-EN_W){1'b0}}, enQ};
    else                    regRdData = '0;
  end

  assign statusWord = statusQ;
  assign enableWord = enQ;
endmodule

// File: rtl/usb_irq_ctrl.sv
module usb_irq_ctrl
  import usb_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              busEvtPulse,
  input  logic              attachEvtPulse,
  input  logic              wakeEvtPulse,
  input  logic [NUM_EP-1:0] epEvtPulse,
  input  logic              setupEvtPulse,
  output logic              irqOut
);
  strobes_t          strb;
  logic [DATA_W-1:0] statusWord;
  logic [EN_W-1:0]   enableWord;

  usb_irq_regctl u_ctl (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .strb     (strb)
  );

  usb_irq_status u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .strb          (strb),
    .busEvtPulse   (busEvtPulse),
    .attachEvtPulse(attachEvtPulse),
    .wakeEvtPulse  (wakeEvtPulse),
    .epEvtPulse    (epEvtPulse),
    .setupEvtPulse (setupEvtPulse),
    .statusWord    (statusWord),
    .enableWord    (enableWord),
    .regRdData     (regRdData),
    .irqOut        (irqOut)
  );
endmodule

// File: rtl/usb_irq_ctrl_chk.sv
module usb_irq_ctrl_chk
  import usb_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic              busEvtPulse,
  input logic              attachEvtPulse,
  input logic              wakeEvtPulse,
  input logic [NUM_EP-1:0] epEvtPulse,
  input logic              setupEvtPulse,
  input logic              irqOut,
  input logic [DATA_W-1:0] statusWord,
  input logic [EN_W-1:0]   enableWord
);
  logic wrStat;
  logic anyPulse;

  assign wrStat   = regWrEn && (regAddr == ADDR_STATUS);
  assign anyPulse = busEvtPulse | attachEvtPulse | wakeEvtPulse | (|epEvtPulse) | setupEvtPulse;

  a_r2_ep_sets_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (|epEvtPulse) |=> statusWord[BIT_USB]);

  a_r7_bus_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    busEvtPulse |=> statusWord[BIT_BUS]);

  a_r3_zero_write_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (wrStat && (regWrData == '0) && !anyPulse) |=> $stable(statusWord));

  a_r5_summary_clear_takes_endpoints: assert property (@(posedge clk) disable iff (!rst_n)
    (wrStat && regWrData[BIT_USB] && !anyPulse)
      |=> ((statusWord[BIT_EP0 +: NUM_EP] == '0) && !statusWord[BIT_USB]));

  a_r6_setup_survives: assert property (@(posedge clk) disable iff (!rst_n)
    (statusWord[BIT_SETUP] && !(wrStat && regWrData[BIT_SETUP])) |=> statusWord[BIT_SETUP]);

  a_r8_enable_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (regAddr == ADDR_ENABLE) |-> (regRdData[DATA_W-1:EN_W] == '0));

  a_r9_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (enableWord == '0) |-> !irqOut);
endmodule

bind usb_irq_ctrl usb_irq_ctrl_chk u_chk (.*);

// File: tb/usb_irq_ctrl_bench.sv
`timescale 1ns/1ps
module usb_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic        busEvtPulse = 1'b0;
  logic        attachEvtPulse = 1'b0;
  logic        wakeEvtPulse = 1'b0;
  logic [5:0]  epEvtPulse = 6'd0;
  logic        setupEvtPulse = 1'b0;
  logic        irqOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  usb_irq_ctrl u_usb_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .busEvtPulse(busEvtPulse),
    .attachEvtPulse(attachEvtPulse), .wakeEvtPulse(wakeEvtPulse),
    .epEvtPulse(epEvtPulse), .setupEvtPulse(setupEvtPulse), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // One cycle of stimulus, driven at a falling edge, released at the next one.
  task automatic step(input logic wr, input logic [1:0] a, input logic [31:0] d,
                      input logic bus, input logic att, input logic wake,
                      input logic [5:0] ep, input logic setup);
    @(negedge clk);
    regWrEn = wr; regAddr = a; regWrData = d;
    busEvtPulse = bus; attachEvtPulse = att; wakeEvtPulse = wake;
    epEvtPulse = ep; setupEvtPulse = setup;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = 32'd0;
    busEvtPulse = 1'b0; attachEvtPulse = 1'b0; wakeEvtPulse = 1'b0;
    epEvtPulse = 6'd0; setupEvtPulse = 1'b0;
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d);
    step(1'b1, a, d, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0);
  endtask

  task automatic pulse(input logic bus, input logic att, input logic wake,
                       input logic [5:0] ep, input logic setup);
    step(1'b0, 2'd0, 32'd0, bus, att, wake, ep, setup);
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    readReg(2'd0, v); check("R1 status after reset", v, 32'h0);
    readReg(2'd1, v); check("R1 enable after reset", v, 32'h0);
    check("R1 irq after reset", {31'd0, irqOut}, 32'h0);
  endtask

  task automatic t_set_flags();
    logic [31:0] v;
    pulse(1'b1, 1'b1, 1'b1, 6'd0, 1'b0);
    readReg(2'd0, v); check("R2 bus/attach/wake set", v, 32'h0000000D);
    pulse(1'b0, 1'b0, 1'b0, 6'b001000, 1'b0);
    readReg(2'd0, v); check("R2 ep3 sets bit19 and bit1", v, 32'h0008000F);
    pulse(1'b0, 1'b0, 1'b0, 6'd0, 1'b1);
    readReg(2'd0, v); check("R2 setup sets bit31", v, 32'h8008000F);
    wrReg(2'd0, 32'hFFFFFFFF);
    readReg(2'd0, v); check("R3 clear all", v, 32'h0);
  endtask

  task automatic t_simple_clear();
    logic [31:0] v;
    pulse(1'b1, 1'b1, 1'b1, 6'd0, 1'b0);
    wrReg(2'd0, 32'h0);
    readReg(2'd0, v); check("R3 zero write no effect", v, 32'h0000000D);
    wrReg(2'd0, 32'h00000004);
    readReg(2'd0, v); check("R3 clear attach only", v, 32'h00000009);
    wrReg(2'd0, 32'h00000009);
    readReg(2'd0, v); check("R3 clear bus and wake", v, 32'h0);
  endtask

  task automatic t_coupled();
    logic [31:0] v;
    pulse(1'b0, 1'b0, 1'b0, 6'b010100, 1'b0);
    readReg(2'd0, v); check("R2 ep2 and ep4 set", v, 32'h00140002);
    wrReg(2'd0, 32'h00040000);
    readReg(2'd0, v); check("R4 ep clear takes summary", v, 32'h00100000);
    pulse(1'b0, 1'b0, 1'b0, 6'b000001, 1'b1);
    readReg(2'd0, v); check("R2 ep0 and setup set", v, 32'h80110002);
    wrReg(2'd0, 32'h00000002);
    readReg(2'd0, v); check("R5 R6 summary clear takes endpoints keeps setup", v, 32'h80000000);
    pulse(1'b0, 1'b0, 1'b0, 6'b000010, 1'b0);
    wrReg(2'd0, 32'h80000000);
    readReg(2'd0, v); check("R4 setup clear takes summary", v, 32'h00020000);
    wrReg(2'd0, 32'h00020000);
    readReg(2'd0, v); check("R5 own endpoint clear", v, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    step(1'b1, 2'd0, 32'h00000001, 1'b1, 1'b0, 1'b0, 6'd0, 1'b0);
    readReg(2'd0, v); check("R7 bus set beats clear", v, 32'h00000001);
    step(1'b1, 2'd0, 32'h00000002, 1'b0, 1'b0, 1'b0, 6'b100000, 1'b0);
    readReg(2'd0, v); check("R7 ep5 set beats summary clear", v, 32'h00200003);
    wrReg(2'd0, 32'hFFFFFFFF);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wrReg(2'd1, 32'hFFFFFFF0);
    readReg(2'd1, v); check("R8 upper bits ignored", v, 32'h0);
    wrReg(2'd1, 32'hFFFFFFFF);
    readReg(2'd1, v); check("R8 enable readback", v, 32'h0000000F);
    wrReg(2'd0, 32'hFFFFFFFF);
    readReg(2'd1, v); check("R8 status write keeps enable", v, 32'h0000000F);
    wrReg(2'd1, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    pulse(1'b1, 1'b0, 1'b0, 6'd0, 1'b0);
    readReg(2'd0, v); check("R10 flag set while disabled", v, 32'h00000001);
    check("R10 irq low while disabled", {31'd0, irqOut}, 32'h0);
    wrReg(2'd1, 32'h1);
    check("R10 irq rises on late enable", {31'd0, irqOut}, 32'h1);
    wrReg(2'd1, 32'h2);
    check("R9 bus not in usb group", {31'd0, irqOut}, 32'h0);
    pulse(1'b0, 1'b0, 1'b0, 6'd0, 1'b1);
    check("R9 setup raises irq", {31'd0, irqOut}, 32'h1);
    wrReg(2'd0, 32'h00000002);
    check("R9 setup alone gated by usb enable", {31'd0, irqOut}, 32'h1);
    wrReg(2'd1, 32'h4);
    check("R9 usb group masked", {31'd0, irqOut}, 32'h0);
    pulse(1'b0, 1'b1, 1'b0, 6'd0, 1'b0);
    check("R9 attach raises irq", {31'd0, irqOut}, 32'h1);
    wrReg(2'd1, 32'h8);
    check("R9 attach masked", {31'd0, irqOut}, 32'h0);
    pulse(1'b0, 1'b0, 1'b1, 6'd0, 1'b0);
    check("R9 wake raises irq", {31'd0, irqOut}, 32'h1);
    wrReg(2'd0, 32'hFFFFFFFF);
    check("R9 irq drops after clear", {31'd0, irqOut}, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_set_flags();
    t_simple_clear();
    t_coupled();
    t_set_wins();
    t_enable();
    t_irq();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule